// File: doc/BRIEF.md
# Packet Receive Framer with Address Filtering

The framer sits behind a demodulator and consumes one received bit per strobe. While idle it hunts for a programmable start pattern of 8 to 32 bits, which must match exactly. Once the pattern is seen, it assembles bytes MSB first. The first byte is the payload length L. Exactly L payload bytes follow, and the first of them is a node address that passes through a selectable filter. A 16-bit CRC closes the frame. Only accepted payload bytes are written to an external byte FIFO. The preamble, the start pattern, the length byte and the CRC bytes never reach the FIFO.

The CRC is the CCITT polynomial 0x1021 with the register preset to 0xFFFF. It covers the payload bytes, the address byte included, and is sent high byte first. A good frame raises a data-ready pulse. A bad frame raises an error pulse. Under the discard policy the framer also strobes a rollback request so that the FIFO drops the frame it has already taken. Software can instead gate FIFO filling by hand with a fill-enable bit, and the framing and checking then go on unchanged.

Top module: `pkt_rx_framer`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, every pulse output is low and the framer is searching for the start pattern.
- R2: `start_det_p` is high for exactly one cycle, the cycle after the clock edge that sampled the last bit completing a match. A match means the most recent N received bits (MSB first) equal bits N-1..0 of `cfg_sync_word`, where N is `cfg_sync_len` clamped to the range 8..32. A match needs at least N bits received since the search began.
- R3: The 8 bits after the start pattern are the length byte L, MSB first. It is never written to the FIFO. L = 0 ends the frame at once with no write, no address pulse and no CRC outcome, and the search starts again.
- R4: L payload bytes follow, each assembled MSB first. An accepted byte appears on `fifo_wr_data` with a one-cycle `fifo_wr_en` in the cycle after its last bit was sampled.
- R5: The first payload byte is the address. `cfg_addr_mode` 0 accepts any value. Mode 1 accepts only `cfg_node_addr`. Mode 2 accepts that value or 0x00. Mode 3 accepts that value, 0x00 or 0xFF. On acceptance, `addr_match_p` pulses in the same cycle as the address byte's write slot. On rejection nothing of the frame is written, no CRC outcome is given, and the search starts again.
- R6: With `cfg_manual_fill` = 0, filling starts automatically with each detected frame. With `cfg_manual_fill` = 1, a payload byte is written only if `cfg_fill_on` is 1 in the cycle that its last bit is sampled. Framing, address pulses and CRC outcomes are not affected by this gating.
- R7: After the payload come two CRC bytes, high byte first. When the CRC matches, `data_rdy_p` pulses once in the cycle after the last CRC bit was sampled.
- R8: When the CRC does not match, `crc_err_p` pulses in that cycle instead. `fifo_discard` pulses in the same cycle exactly when `cfg_discard_bad` is 1.
- R9: Cycles with `bit_vld` low change nothing, so gaps between bits do not alter any result.
- R10: After a frame ends for any reason, the framer searches again at once, so frames may follow back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Received data bit |
| bit_vld | input | 1 | Strobe: `bit_in` is valid this cycle |
| cfg_sync_word | input | SYNC_MAX | Start pattern, right-aligned |
| cfg_sync_len | input | LEN_W | Start pattern length in bits (clamped 8..32) |
| cfg_node_addr | input | 8 | Own node address |
| cfg_addr_mode | input | 2 | Address filter: 0 any, 1 node, 2 node/0x00, 3 node/0x00/0xFF |
| cfg_manual_fill | input | 1 | 0: fill on detection, 1: fill under `cfg_fill_on` |
| cfg_fill_on | input | 1 | Manual fill enable |
| cfg_discard_bad | input | 1 | 1: roll back frames with CRC errors |
| start_det_p | output | 1 | Start pattern detected pulse |
| addr_match_p | output | 1 | Address accepted pulse |
| fifo_wr_en | output | 1 | FIFO write strobe, one pulse per written byte |
| fifo_wr_data | output | 8 | FIFO write data |
| fifo_discard | output | 1 | Roll the FIFO back to the frame start |
| data_rdy_p | output | 1 | Frame complete with good CRC |
| crc_err_p | output | 1 | Frame complete with bad CRC |

## Verification
The address acceptance and the write of that same address byte happen in one cycle. The bench therefore counts the cycles in which `addr_match_p` and `fifo_wr_en` are high together across a sweep of every filter mode against node, 0x00, 0xFF and foreign addresses. Each count must equal the number of accepted frames. The bench also splits the two events on purpose: in manual mode it drops the fill enable in the very cycle that the address byte's last bit is sampled. The address pulse must still appear, no byte may be written, and the CRC verdict must still arrive.

// File: rtl/prf_pkg.sv
package prf_pkg;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_LEN  = 2'd1,
    ST_BODY = 2'd2,
    ST_CRC  = 2'd3
  } prf_state_e;

  typedef enum logic [1:0] {
    AF_ANY   = 2'd0,
    AF_EXACT = 2'd1,
    AF_ZERO  = 2'd2,
    AF_BOTH  = 2'd3
  } prf_afmode_e;

endpackage

// File: rtl/prf_sync_hunt.sv
module prf_sync_hunt #(
  parameter int SYNC_MAX = 32,
  parameter int LEN_W    = 6,
  parameter int MIN_LEN  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bit_in,
  input  logic                bit_vld,
  input  logic                arm,
  input  logic [SYNC_MAX-1:0] word,
  input  logic [LEN_W-1:0]    len,
  output logic                hit
);

  localparam int CNT_W = $clog2(SYNC_MAX + 1);

  logic [SYNC_MAX-1:0] sr_q;
  logic [SYNC_MAX-1:0] sr_nxt;
  logic [SYNC_MAX-1:0] mask;
  logic [CNT_W-1:0]    cnt_q;
  logic [CNT_W-1:0]    eff_len;
  logic                filled;

  always_comb begin
    if (int'(len) < MIN_LEN)       eff_len = CNT_W'(MIN_LEN);
    else if (int'(len) > SYNC_MAX) eff_len = CNT_W'(SYNC_MAX);
    else                           eff_len = CNT_W'(len);
  end

  for (genvar g = 0; g < SYNC_MAX; g++) begin : g_mask
    assign mask[g] = (g < int'(eff_len));
  end

  assign sr_nxt = {sr_q[SYNC_MAX-2:0], bit_in};
  assign filled = (int'(cnt_q) + 1 >= int'(eff_len));
  assign hit    = arm & bit_vld & filled & (((sr_nxt ^ word) & mask) == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (!arm) begin
      cnt_q <= '0;
    end else if (bit_vld) begin
      sr_q <= sr_nxt;
      if (int'(cnt_q) < SYNC_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/prf_crc_ser.sv
module prf_crc_ser #(
  parameter int           W    = 16,
  parameter logic [W-1:0] POLY = 16'h1021,
  parameter logic [W-1:0] INIT = 16'hFFFF
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic en,
  input  logic bit_in,
  output logic zero_nxt
);

  logic [W-1:0] crc_q;
  logic [W-1:0] crc_nxt;
  logic         fb;

  assign fb       = crc_q[W-1] ^ bit_in;
  assign crc_nxt  = {crc_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);
  assign zero_nxt = (crc_nxt == '0);

  always_ff @(posedge clk) begin
    if (rst)       crc_q <= INIT;
    else if (load) crc_q <= INIT;
    else if (en)   crc_q <= crc_nxt;
  end

endmodule

// File: rtl/prf_addr_filter.sv
module prf_addr_filter #(
  parameter int AW = 8
) (
  input  logic [AW-1:0]       addr,
  input  logic [AW-1:0]       node,
  input  prf_pkg::prf_afmode_e mode,
  output logic                accept
);

  logic is_node;
  logic is_zero;
  logic is_ones;

  assign is_node = (addr == node);
  assign is_zero = (addr == '0);
  assign is_ones = &addr;

  always_comb begin
    unique case (mode)
      prf_pkg::AF_ANY:   accept = 1'b1;
      prf_pkg::AF_EXACT: accept = is_node;
      prf_pkg::AF_ZERO:  accept = is_node | is_zero;
      default:           accept = is_node | is_zero | is_ones;
    endcase
  end

endmodule

// File: rtl/pkt_rx_framer.sv
module pkt_rx_framer #(
  parameter int              SYNC_MAX = 32,
  parameter int              LEN_W    = 6,
  parameter int              BYTE_W   = 8,
  parameter int              CRC_W    = 16,
  parameter logic [CRC_W-1:0] CRC_POLY = 16'h1021,
  parameter logic [CRC_W-1:0] CRC_INIT = 16'hFFFF
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bit_in,
  input  logic                bit_vld,
  input  logic [SYNC_MAX-1:0] cfg_sync_word,
  input  logic [LEN_W-1:0]    cfg_sync_len,
  input  logic [BYTE_W-1:0]   cfg_node_addr,
  input  logic [1:0]          cfg_addr_mode,
  input  logic                cfg_manual_fill,
  input  logic                cfg_fill_on,
  input  logic                cfg_discard_bad,
  output logic                start_det_p,
  output logic                addr_match_p,
  output logic                fifo_wr_en,
  output logic [BYTE_W-1:0]   fifo_wr_data,
  output logic                fifo_discard,
  output logic                data_rdy_p,
  output logic                crc_err_p
);

  import prf_pkg::*;

  localparam int BC_W  = $clog2(BYTE_W);
  localparam int CRC_C = $clog2(CRC_W);
  localparam int CNT_W = (CRC_C > BC_W) ? CRC_C : BC_W;

  prf_state_e          state_q;
  logic [CNT_W-1:0]    bitcnt_q;
  logic [BYTE_W-2:0]   sh_q;
  logic [BYTE_W-1:0]   byte_nxt;
  logic [BYTE_W-1:0]   remain_q;
  logic                first_q;
  logic                byte_done;
  logic                crc_done;
  logic                sync_hit;
  logic                addr_ok;
  logic                crc_zero;
  logic                crc_load;
  logic                crc_en;
  logic                fill_en;

  assign byte_nxt  = {sh_q, bit_in};
  assign byte_done = (bitcnt_q[BC_W-1:0] == '1);
  assign crc_done  = (int'(bitcnt_q) == CRC_W - 1);
  assign fill_en   = ~cfg_manual_fill | cfg_fill_on;
  assign crc_load  = bit_vld && (state_q == ST_LEN) && byte_done;
  assign crc_en    = bit_vld && ((state_q == ST_BODY) || (state_q == ST_CRC));

  prf_sync_hunt #(
    .SYNC_MAX (SYNC_MAX),
    .LEN_W    (LEN_W),
    .MIN_LEN  (8)
  ) hunt_i (
    .clk     (clk),
    .rst     (rst),
    .bit_in  (bit_in),
    .bit_vld (bit_vld),
    .arm     (state_q == ST_HUNT),
    .word    (cfg_sync_word),
    .len     (cfg_sync_len),
    .hit     (sync_hit)
  );

  prf_crc_ser #(
    .W    (CRC_W),
    .POLY (CRC_POLY),
    .INIT (CRC_INIT)
  ) crc_i (
    .clk      (clk),
    .rst      (rst),
    .load     (crc_load),
    .en       (crc_en),
    .bit_in   (bit_in),
    .zero_nxt (crc_zero)
  );

  prf_addr_filter #(
    .AW (BYTE_W)
  ) filt_i (
    .addr   (byte_nxt),
    .node   (cfg_node_addr),
    .mode   (prf_afmode_e'(cfg_addr_mode)),
    .accept (addr_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_HUNT;
      bitcnt_q     <= '0;
      sh_q         <= '0;
      remain_q     <= '0;
      first_q      <= 1'b0;
      start_det_p  <= 1'b0;
      addr_match_p <= 1'b0;
      fifo_wr_en   <= 1'b0;
      fifo_wr_data <= '0;
      fifo_discard <= 1'b0;
      data_rdy_p   <= 1'b0;
      crc_err_p    <= 1'b0;
    end else begin
      start_det_p  <= 1'b0;
      addr_match_p <= 1'b0;
      fifo_wr_en   <= 1'b0;
      fifo_discard <= 1'b0;
      data_rdy_p   <= 1'b0;
      crc_err_p    <= 1'b0;
      if (bit_vld) begin
        unique case (state_q)
          ST_HUNT: begin
            if (sync_hit) begin
              state_q     <= ST_LEN;
              bitcnt_q    <= '0;
              start_det_p <= 1'b1;
            end
          end
          ST_LEN: begin
            sh_q     <= byte_nxt[BYTE_W-2:0];
            bitcnt_q <= bitcnt_q + 1'b1;
            if (byte_done) begin
              bitcnt_q <= '0;
              first_q  <= 1'b1;
              remain_q <= byte_nxt;
              state_q  <= (byte_nxt == '0) ? ST_HUNT : ST_BODY;
            end
          end
          ST_BODY: begin
            sh_q     <= byte_nxt[BYTE_W-2:0];
            bitcnt_q <= bitcnt_q + 1'b1;
            if (byte_done) begin
              bitcnt_q <= '0;
              first_q  <= 1'b0;
              if (first_q && !addr_ok) begin
                state_q <= ST_HUNT;
              end else begin
                addr_match_p <= first_q;
                if (fill_en) begin
                  fifo_wr_en   <= 1'b1;
                  fifo_wr_data <= byte_nxt;
                end
                remain_q <= remain_q - 1'b1;
                if (remain_q == BYTE_W'(1)) state_q <= ST_CRC;
              end
            end
          end
          default: begin
            bitcnt_q <= bitcnt_q + 1'b1;
            if (crc_done) begin
              bitcnt_q     <= '0;
              state_q      <= ST_HUNT;
              data_rdy_p   <= crc_zero;
              crc_err_p    <= ~crc_zero;
              fifo_discard <= ~crc_zero & cfg_discard_bad;
            end
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/pkt_rx_framer_chk.sv
module pkt_rx_framer_chk (
  input logic clk,
  input logic rst,
  input logic start_det_p,
  input logic addr_match_p,
  input logic fifo_wr_en,
  input logic fifo_discard,
  input logic data_rdy_p,
  input logic crc_err_p,
  input logic cfg_manual_fill,
  input logic cfg_fill_on,
  input logic cfg_discard_bad
);

  assert_start_single_R2: assert property (@(posedge clk) disable iff (rst)
    start_det_p |=> !start_det_p);

  assert_start_no_write_R3: assert property (@(posedge clk) disable iff (rst)
    start_det_p |-> (!fifo_wr_en && !addr_match_p));

  assert_match_writes_R5: assert property (@(posedge clk) disable iff (rst)
    (addr_match_p && !$past(cfg_manual_fill)) |-> fifo_wr_en);

  assert_fill_gate_R6: assert property (@(posedge clk) disable iff (rst)
    fifo_wr_en |-> (!$past(cfg_manual_fill) || $past(cfg_fill_on)));

  assert_one_verdict_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({data_rdy_p, crc_err_p, fifo_wr_en}));

  assert_discard_on_err_R8: assert property (@(posedge clk) disable iff (rst)
    fifo_discard |-> crc_err_p);

  assert_discard_policy_R8: assert property (@(posedge clk) disable iff (rst)
    crc_err_p |-> (fifo_discard == $past(cfg_discard_bad)));

endmodule

bind pkt_rx_framer pkt_rx_framer_chk chk_i (
  .clk             (clk),
  .rst             (rst),
  .start_det_p     (start_det_p),
  .addr_match_p    (addr_match_p),
  .fifo_wr_en      (fifo_wr_en),
  .fifo_discard    (fifo_discard),
  .data_rdy_p      (data_rdy_p),
  .crc_err_p       (crc_err_p),
  .cfg_manual_fill (cfg_manual_fill),
  .cfg_fill_on     (cfg_fill_on),
  .cfg_discard_bad (cfg_discard_bad)
);

// File: tb/pkt_rx_framer_tb_top.sv
module pkt_rx_framer_tb_top;

  localparam logic [31:0] SW   = 32'h2DD491C7;
  localparam logic [7:0]  NODE = 8'h5A;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bit_in = 1'b0;
  logic        bit_vld = 1'b0;
  logic [31:0] cfg_sync_word = SW;
  logic [5:0]  cfg_sync_len = 6'd16;
  logic [7:0]  cfg_node_addr = NODE;
  logic [1:0]  cfg_addr_mode = 2'd0;
  logic        cfg_manual_fill = 1'b0;
  logic        cfg_fill_on = 1'b0;
  logic        cfg_discard_bad = 1'b0;
  logic        start_det_p, addr_match_p, fifo_wr_en, fifo_discard, data_rdy_p, crc_err_p;
  logic [7:0]  fifo_wr_data;

  always #4 clk = ~clk;

  pkt_rx_framer dut_i (
    .clk(clk), .rst(rst), .bit_in(bit_in), .bit_vld(bit_vld),
    .cfg_sync_word(cfg_sync_word), .cfg_sync_len(cfg_sync_len),
    .cfg_node_addr(cfg_node_addr), .cfg_addr_mode(cfg_addr_mode),
    .cfg_manual_fill(cfg_manual_fill), .cfg_fill_on(cfg_fill_on),
    .cfg_discard_bad(cfg_discard_bad),
    .start_det_p(start_det_p), .addr_match_p(addr_match_p),
    .fifo_wr_en(fifo_wr_en), .fifo_wr_data(fifo_wr_data),
    .fifo_discard(fifo_discard), .data_rdy_p(data_rdy_p), .crc_err_p(crc_err_p)
  );

  int n_chk = 0, n_fail = 0;
  int gap = 0, drop_idx = -1, sync_bits = 16;
  int c_start = 0, c_addr = 0, c_wr = 0, c_rdy = 0, c_err = 0, c_disc = 0, c_coin = 0;
  int b_start, b_addr, b_wr, b_rdy, b_err, b_disc, b_coin;
  logic [7:0] wq [0:1023];
  logic [7:0] pl [0:15];

  always @(negedge clk) begin
    if (!rst) begin
      if (start_det_p)  c_start++;
      if (addr_match_p) c_addr++;
      if (data_rdy_p)   c_rdy++;
      if (crc_err_p)    c_err++;
      if (fifo_discard) c_disc++;
      if (addr_match_p && fifo_wr_en) c_coin++;
      if (fifo_wr_en) begin
        wq[c_wr % 1024] = fifo_wr_data;
        c_wr++;
      end
    end
  end

  task automatic check_eq(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic snap();
    b_start = c_start; b_addr = c_addr; b_wr = c_wr; b_rdy = c_rdy;
    b_err = c_err; b_disc = c_disc; b_coin = c_coin;
  endtask

  task automatic send_bit(input logic b);
    bit_in = b; bit_vld = 1'b1;
    @(negedge clk);
    bit_vld = 1'b0; bit_in = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic send_pre();
    for (int i = 0; i < 16; i++) send_bit(~i[0]);
  endtask

  task automatic send_sync(input int n);
    for (int i = n - 1; i >= 0; i--) send_bit(SW[i]);
  endtask

  function automatic logic [15:0] crc_of(input int n);
    logic [15:0] c = 16'hFFFF;
    for (int k = 0; k < n; k++)
      for (int i = 7; i >= 0; i--)
        c = {c[14:0], 1'b0} ^ ((c[15] ^ pl[k][i]) ? 16'h1021 : 16'h0000);
    return c;
  endfunction

  task automatic send_body(input int n, input bit bad);
    logic [15:0] c;
    c = crc_of(n) ^ (bad ? 16'h0001 : 16'h0000);
    send_byte(n[7:0]);
    for (int k = 0; k < n; k++)
      for (int i = 7; i >= 0; i--) begin
        if (i == 0 && k == drop_idx) cfg_fill_on = 1'b0;
        send_bit(pl[k][i]);
      end
    send_byte(c[15:8]);
    send_byte(c[7:0]);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
    #1;
  endtask

  task automatic send_pkt(input int n, input bit bad);
    send_pre();
    send_sync(sync_bits);
    send_body(n, bad);
    settle();
  endtask

  task automatic check_data(input string tag, input int n);
    for (int k = 0; k < n; k++) check_eq(tag, int'(wq[(b_wr + k) % 1024]), int'(pl[k]));
  endtask

  initial begin
    int acc;
    logic [7:0] av;
    pl[0] = NODE; pl[1] = 8'h12; pl[2] = 8'hC4;
    repeat (3) @(negedge clk);
    #1;
    check_eq("R1 reset pulses", int'({start_det_p, addr_match_p, fifo_wr_en, fifo_discard, data_rdy_p, crc_err_p}), 0);
    rst = 1'b0;
    @(negedge clk);
    #1;
    check_eq("R1 after release", int'({start_det_p, addr_match_p, fifo_wr_en, fifo_discard, data_rdy_p, crc_err_p}), 0);

    // R2/R4/R7: sync length sweep with exact detect timing
    foreach (pl[i]) if (i > 2) pl[i] = 8'(i * 37 + 5);
    for (int s = 0; s < 6; s++) begin
      int lens [6] = '{8, 13, 24, 32, 5, 40};
      int eff;
      eff = (lens[s] < 8) ? 8 : (lens[s] > 32) ? 32 : lens[s];
      cfg_sync_len = 6'(lens[s]);
      snap();
      send_pre();
      send_sync(eff);
      #1;
      check_eq("R2 detect cycle", int'(start_det_p), 1);
      send_body(3, 1'b0);
      settle();
      check_eq("R2 single detect", c_start - b_start, 1);
      check_eq("R4 write count", c_wr - b_wr, 3);
      check_data("R4 data", 3);
      check_eq("R7 good crc", c_rdy - b_rdy, 1);
    end
    cfg_sync_len = 6'd16;

    // R5: address filter sweep over every mode and address class
    for (int m = 0; m < 4; m++)
      for (int a = 0; a < 4; a++) begin
        av = (a == 0) ? NODE : (a == 1) ? 8'h00 : (a == 2) ? 8'hFF : 8'h33;
        acc = (m == 0 || a == 0 || (m >= 2 && a == 1) || (m == 3 && a == 2)) ? 1 : 0;
        cfg_addr_mode = 2'(m);
        pl[0] = av;
        snap();
        send_pkt(3, 1'b0);
        check_eq("R5 writes", c_wr - b_wr, acc * 3);
        check_eq("R5 addr pulse", c_addr - b_addr, acc);
        check_eq("R5 same cycle", c_coin - b_coin, acc);
        check_eq("R5 verdict", c_rdy - b_rdy + c_err - b_err, acc);
        if (acc == 1) check_data("R5 data", 3);
      end
    cfg_addr_mode = 2'd1;
    pl[0] = NODE;

    // R8: bad CRC under both policies
    for (int d = 0; d < 2; d++) begin
      cfg_discard_bad = d[0];
      snap();
      send_pkt(3, 1'b1);
      check_eq("R8 err pulse", c_err - b_err, 1);
      check_eq("R8 no ready", c_rdy - b_rdy, 0);
      check_eq("R8 discard", c_disc - b_disc, d);
    end
    cfg_discard_bad = 1'b1;
    snap();
    send_pkt(3, 1'b0);
    check_eq("R8 good no discard", c_disc - b_disc, 0);

    // R6: manual fill gating
    cfg_manual_fill = 1'b1;
    cfg_fill_on = 1'b0;
    snap();
    send_pkt(3, 1'b0);
    check_eq("R6 gated off writes", c_wr - b_wr, 0);
    check_eq("R6 gated off verdict", c_rdy - b_rdy, 1);
    check_eq("R6 gated off addr", c_addr - b_addr, 1);
    cfg_fill_on = 1'b1;
    snap();
    send_pkt(3, 1'b0);
    check_eq("R6 gated on writes", c_wr - b_wr, 3);
    // R5/R6 same-cycle split: fill drops on the address byte's last bit
    drop_idx = 0;
    snap();
    send_pkt(3, 1'b0);
    drop_idx = -1;
    check_eq("R6 split writes", c_wr - b_wr, 0);
    check_eq("R5 split addr pulse", c_addr - b_addr, 1);
    check_eq("R7 split verdict", c_rdy - b_rdy, 1);
    cfg_manual_fill = 1'b0;

    // R3/R10: zero length frame, then an immediate frame
    snap();
    send_pre();
    send_sync(16);
    send_byte(8'h00);
    send_sync(16);
    send_body(3, 1'b0);
    settle();
    check_eq("R3 zero len detects", c_start - b_start, 2);
    check_eq("R3 zero len writes", c_wr - b_wr, 3);
    check_eq("R10 following frame", c_rdy - b_rdy, 1);
    check_eq("R3 no error", c_err - b_err, 0);

    // R10: back to back frames with no idle
    snap();
    send_pre();
    send_sync(16);
    send_body(3, 1'b0);
    send_sync(16);
    send_body(3, 1'b1);
    settle();
    check_eq("R10 two detects", c_start - b_start, 2);
    check_eq("R10 verdicts", (c_rdy - b_rdy) * 10 + (c_err - b_err), 11);

    // R9: gaps between bits
    gap = 3;
    snap();
    send_pkt(5, 1'b0);
    gap = 0;
    check_eq("R9 gap writes", c_wr - b_wr, 5);
    check_data("R9 gap data", 5);
    check_eq("R9 gap verdict", c_rdy - b_rdy, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule